// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the data-out pin of a 12-bit serial converter. A test environment or a bus-functional model puts the word to be reported on a parallel input. A serial master drives a chip-select (active low) and a serial clock. The block then plays back the data-out waveform such a converter would produce.

The frame works as follows:

- The frame opens when chip-select falls, and the parallel word is captured at that moment.
- The output stays undriven for the first clocks of the frame.
- Next comes a single zero bit.
- Then the captured word goes out most significant bit first.
- If the master keeps clocking after the last bit, the same word is replayed least significant bit first, beginning one bit above the LSB.
- After the replay, the output stays undriven until chip-select rises.

The output changes only after falling edges of the serial clock, so the clock may idle low or idle high. The undriven state is shown by a low output-enable.

The block runs on a fast system clock. Chip-select and the serial clock pass through synchronizer flops, and their edges are found on the system clock. Both output pins are registered.

Top module: `adc_sdo_emu`

## Requirements
- R1: During and right after synchronous reset, `sdo_oe` and `sdo` are both 0.
- R2: While `cs_n` is high, `sdo_oe` is 0 once the synchronizer latency has passed. Each new falling edge of `cs_n` restarts the sequence from its beginning, even if the previous frame was cut short.
- R3: From the fall of `cs_n` through the first LEAD_FALLS falling edges of `sclk` (default 1), `sdo_oe` is 0.
- R4: After falling edge number LEAD_FALLS+1 of the frame, `sdo_oe` is 1 and `sdo` is 0. This is the null bit, and `sdo_oe` never rises with `sdo` at 1.
- R5: After falling edges LEAD_FALLS+2 through LEAD_FALLS+1+DATA_W, `sdo` carries the captured word from bit DATA_W-1 down to bit 0, one bit per edge, with `sdo_oe` at 1.
- R6: The following DATA_W-1 falling edges replay the word in ascending order, bit 1 up to bit DATA_W-1, with `sdo_oe` at 1.
- R7: Every falling edge after the replay leaves `sdo_oe` at 0 until `cs_n` rises.
- R8: `sdo` and `sdo_oe` change only in response to a falling `sclk` edge or a `cs_n` edge. A rising `sclk` edge leaves them unchanged.
- R9: `sample_in` is captured when `cs_n` falls. Changing it later in the frame has no effect on the bits sent.
- R10: The sequence is identical whether `sclk` idles low or idles high between frames.
- R11: Whenever `sdo_oe` is 0, `sdo` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select from the serial master, active low |
| sclk | input | 1 | Serial clock from the master, either idle level |
| sample_in | input | DATA_W | Word to report, captured when `cs_n` falls |
| sdo | output | 1 | Serial data out, 0 while not driven |
| sdo_oe | output | 1 | Output enable; 0 represents high impedance |

## Verification
The bench builds the block with its defaults:

- DATA_W of 12 gives a 12-bit word.
- LEAD_FALLS of 1 places the null bit on the second falling edge and the MSB on the third.
- SYNC_STAGES of 2 puts a four-cycle latency between a pin edge and the output.

Frames run up to 30 falling edges, so every phase is reached: the lead, the null bit, both data orders and the idle tail. Frames are also cut off at random points, which exercises restarts. The serial half period is eight system clocks, well beyond the synchronizer latency. Checks are taken both after falling edges and after rising edges, so a response to the wrong edge is caught.

// File: rtl/adc_sdo_emu_pkg.sv
package adc_sdo_emu_pkg;

  // Position of a frame within its output sequence
  typedef enum logic [2:0] {
    PH_LEAD = 3'd0,  // undriven opening clocks
    PH_NULL = 3'd1,  // single zero bit
    PH_MSB  = 3'd2,  // word, high bit first
    PH_LSB  = 3'd3,  // replay, low bit first
    PH_TAIL = 3'd4   // undriven after replay
  } phase_e;

  // Map a falling-edge count to its phase
  function automatic phase_e phase_of(input int n, input int lead, input int width);
    if (n <= lead)                    return PH_LEAD;
    else if (n == lead + 1)           return PH_NULL;
    else if (n <= lead + 1 + width)   return PH_MSB;
    else if (n <= lead + 2 * width)   return PH_LSB;
    else                              return PH_TAIL;
  endfunction

endpackage

// File: rtl/adc_sdo_sync_edge.sv
// Synchronizes one pin into the clk domain and flags its falling edge.
module adc_sdo_sync_edge #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic fall
);

  logic synced;
  logic level_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign synced = pin;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], pin};
      end
      assign synced = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_q <= RESET_VAL;
    else     level_q <= synced;
  end

  assign level = synced;
  assign fall  = level_q & ~synced;

endmodule

// File: rtl/adc_sdo_frame_ctl.sv
// Counts serial clock falls within a frame and holds the captured word.
module adc_sdo_frame_ctl #(
  parameter int DATA_W  = 12,
  parameter int CNT_MAX = 26,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_level,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] sample_in,
  output logic [CNT_W-1:0]  fall_cnt,
  output logic [DATA_W-1:0] held
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      held     <= '0;
    end else if (cs_level) begin
      fall_cnt <= '0;
    end else if (cs_fall) begin
      fall_cnt <= '0;
      held     <= sample_in;
    end else if (sclk_fall && fall_cnt != LIMIT) begin
      fall_cnt <= fall_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_sdo_out_stage.sv
// Decodes the frame position into registered data and enable pins.
module adc_sdo_out_stage
  import adc_sdo_emu_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_FALLS = 1,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fall_cnt,
  input  logic [DATA_W-1:0] held,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  phase_e           phase;
  logic [IDX_W-1:0] bit_idx;
  logic             nxt_d;
  logic             nxt_oe;
  int               n;

  always_comb begin
    n       = int'(fall_cnt);
    phase   = phase_of(n, LEAD_FALLS, DATA_W);
    bit_idx = '0;
    nxt_d   = 1'b0;
    nxt_oe  = 1'b0;
    case (phase)
      PH_NULL: nxt_oe = 1'b1;
      PH_MSB: begin
        bit_idx = IDX_W'(DATA_W - 1 - (n - LEAD_FALLS - 2));
        nxt_d   = held[bit_idx];
        nxt_oe  = 1'b1;
      end
      PH_LSB: begin
        bit_idx = IDX_W'(n - LEAD_FALLS - 1 - DATA_W);
        nxt_d   = held[bit_idx];
        nxt_oe  = 1'b1;
      end
      default: begin
        nxt_d  = 1'b0;
        nxt_oe = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo    <= nxt_d;
      sdo_oe <= nxt_oe;
    end
  end

endmodule

// File: rtl/adc_sdo_emu.sv
module adc_sdo_emu #(
  parameter int DATA_W      = 12,
  parameter int LEAD_FALLS  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_MAX = LEAD_FALLS + 2 * DATA_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              cs_level;
  logic              cs_fall;
  logic              sclk_level;
  logic              sclk_fall;
  logic [CNT_W-1:0]  fall_cnt;
  logic [DATA_W-1:0] held;

  adc_sdo_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .pin(cs_n), .level(cs_level), .fall(cs_fall)
  );

  adc_sdo_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .pin(sclk), .level(sclk_level), .fall(sclk_fall)
  );

  adc_sdo_frame_ctl #(.DATA_W(DATA_W), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst),
    .cs_level(cs_level), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall & ~sclk_level),
    .sample_in(sample_in),
    .fall_cnt(fall_cnt), .held(held)
  );

  adc_sdo_out_stage #(.DATA_W(DATA_W), .LEAD_FALLS(LEAD_FALLS), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .fall_cnt(fall_cnt), .held(held),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

endmodule

// File: rtl/adc_sdo_emu_chk.sv
module adc_sdo_emu_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe
);

  localparam int          LAT   = SYNC_STAGES + 4;
  localparam logic [7:0]  LAT_C = 8'(LAT);

  logic       sclk_q, cs_q;
  logic [7:0] quiet_cnt;
  logic [7:0] cs_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= sclk;
      cs_q      <= cs_n;
      quiet_cnt <= '0;
      cs_hi_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (sclk != sclk_q || cs_n != cs_q) quiet_cnt <= '0;
      else if (quiet_cnt != 8'hFF)        quiet_cnt <= quiet_cnt + 1'b1;
      if (!cs_n)                          cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 8'hFF)        cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end
  end

  // R2: chip-select held high leaves the output undriven
  p_idle_undriven_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt >= LAT_C) |-> !sdo_oe);

  // R4: the driven phase always opens with the zero null bit
  p_null_first_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !sdo);

  // R8: outputs hold while both pins have been quiet
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt >= LAT_C) |-> ($stable(sdo) && $stable(sdo_oe)));

  // R8: enable only rises as a result of a recent pin edge
  p_oe_needs_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> (quiet_cnt < LAT_C));

  // R11: data held low while undriven
  p_undriven_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

endmodule

bind adc_sdo_emu adc_sdo_emu_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/adc_sdo_emu_tb.sv
`timescale 1ns/1ps
module adc_sdo_emu_tb;

  localparam int W    = 12;
  localparam int LEAD = 1;
  localparam int H    = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         sdo, sdo_oe;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  adc_sdo_emu #(.DATA_W(W), .LEAD_FALLS(LEAD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  // Expected pins after n falling edges in a frame
  function automatic void exp_at(input logic [W-1:0] s, input int n,
                                 output logic oe, output logic d);
    int m, r;
    oe = 1'b0; d = 1'b0;
    if (n == LEAD + 1) oe = 1'b1;
    else if (n > LEAD + 1) begin
      m = n - LEAD - 2;
      if (m < W) begin oe = 1'b1; d = s[W-1-m]; end
      else begin
        r = m - W + 1;
        if (r <= W - 1) begin oe = 1'b1; d = s[r]; end
      end
    end
  endfunction

  function automatic string tag_of(input int n);
    if (n <= LEAD)          return "R3";
    if (n == LEAD + 1)      return "R4";
    if (n <= LEAD + 1 + W)  return "R5";
    if (n <= LEAD + 2 * W)  return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic oe_e, input logic d_e);
    checks++;
    if (sdo_oe !== oe_e || sdo !== d_e) begin
      errors++;
      $display("FAIL %s: oe=%0b sdo=%0b expected oe=%0b sdo=%0b",
               tag, sdo_oe, sdo, oe_e, d_e);
    end else if (!oe_e) begin
      checks++; // R11: undriven output observed at zero
    end
  endtask

  task automatic run_frame(input logic [W-1:0] s, input bit idle_hi,
                           input int nfalls, input bit disturb);
    logic  oe_e, d_e;
    string extra;
    extra = "";
    if (idle_hi) extra = {extra, " R10"};
    if (disturb) extra = {extra, " R9"};
    sample_in = s;
    sclk = idle_hi;
    cs_n = 1'b1;
    wait_h();
    cs_n = 1'b0;
    wait_h();
    if (disturb) sample_in = ~s;
    check({"R3", extra}, 1'b0, 1'b0);
    oe_e = 1'b0; d_e = 1'b0;
    for (int k = 1; k <= nfalls; k++) begin
      if (!idle_hi) begin
        sclk = 1'b1; wait_h();
        check({"R8", extra}, oe_e, d_e);
        sclk = 1'b0; wait_h();
        exp_at(s, k, oe_e, d_e);
        check({tag_of(k), extra}, oe_e, d_e);
      end else begin
        sclk = 1'b0; wait_h();
        exp_at(s, k, oe_e, d_e);
        check({tag_of(k), extra}, oe_e, d_e);
        sclk = 1'b1; wait_h();
        check({"R8", extra}, oe_e, d_e);
      end
    end
    cs_n = 1'b1;
    wait_h();
    check("R2", 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    // Directed patterns in both idle levels
    run_frame(12'hA5C, 1'b0, 30, 1'b0);
    run_frame(12'hA5C, 1'b1, 30, 1'b0);  // R10
    run_frame(12'hFFF, 1'b0, 28, 1'b0);
    run_frame(12'h000, 1'b1, 28, 1'b0);
    run_frame(12'h801, 1'b0, 26, 1'b0);
    // R2: aborted frame then a clean restart
    run_frame(12'h3C3, 1'b0, 5, 1'b0);
    run_frame(12'h3C3, 1'b0, 16, 1'b0);
    // R9: sample changed mid-frame
    run_frame(12'h5A1, 1'b0, 27, 1'b1);
    run_frame(12'h0F0, 1'b1, 27, 1'b1);

    // Random frames
    for (int i = 0; i < 40; i++) begin
      run_frame(W'($urandom), 1'($urandom), int'($urandom_range(0, 30)),
                1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule